// File: doc/BRIEF.md
# Interleaved Parity Entry Checker

This block holds the entries of a small translation-style cache and protects each one with two interleaved parity bits. Every entry carries a 71-bit payload. When an entry is written, one even-parity bit is computed over the payload bits at even positions and another over the bits at odd positions. Both bits are stored next to the payload in a codeword held in an internal register array.

A lookup reads the codeword, recomputes both parity bits and compares them with the stored ones. A clean, valid entry returns a hit with its payload. If either group disagrees, the block treats the lookup as a miss and clears the entry's valid bit. For one cycle it also raises a refetch request that carries the entry index, so that an outside engine can fetch a fresh copy.

A test-only flip mask is XORed into the codeword as it is written. This corrupts chosen payload or parity bits and lets the error path be exercised without touching the normal data path.

Top module: `ilp_entry_guard`

## Requirements
- R1: After reset every entry is invalid: a lookup of any index returns a miss, and no refetch is requested until the entry is written.
- R2: A write stores the payload with an even-parity bit at codeword bit 71 (XOR of payload bits 0, 2, ..., 70) and an odd-parity bit at codeword bit 72 (XOR of payload bits 1, 3, ..., 69). A later lookup of that clean entry returns a hit with the written payload.
- R3: `rsp_valid` is high in exactly the cycle after each cycle in which `rd_en` is high, and low otherwise.
- R4: Any single flipped codeword bit is detected. A flip of an even payload bit or of bit 71 sets `rsp_err_even`, and a flip of an odd payload bit or of bit 72 sets `rsp_err_odd`. The response is a miss with an all-zero payload.
- R5: A detected error produces `refetch_req` for exactly one cycle, alongside the miss response, with `refetch_idx` equal to the index that was looked up.
- R6: An entry whose lookup failed its check becomes invalid. Later lookups miss with no error flags and no refetch until the entry is written again.
- R7: Two flipped payload bits at adjacent positions set both `rsp_err_even` and `rsp_err_odd`.
- R8: Two flipped payload bits that are both at even positions go undetected. The lookup hits and returns the corrupted payload.
- R9: A lookup of an invalid entry returns a miss with both error flags low, no refetch and an all-zero payload.
- R10: When a write and a lookup target the same index in the same cycle, the lookup sees the contents from before the write. The write then takes effect, and it overrides any invalidation caused by that lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write an entry this cycle |
| wr_idx | input | 4 | Index of the entry to write |
| wr_payload | input | 71 | Payload to store |
| wr_flip | input | 73 | Test-only mask XORed into the stored codeword (bit 71 even parity, bit 72 odd parity) |
| rd_en | input | 1 | Look up an entry this cycle |
| rd_idx | input | 4 | Index to look up |
| rsp_valid | output | 1 | Lookup response present |
| rsp_hit | output | 1 | Entry valid and both parity groups clean |
| rsp_payload | output | 71 | Payload on a hit, zero otherwise |
| rsp_err_even | output | 1 | Even-position group failed its check |
| rsp_err_odd | output | 1 | Odd-position group failed its check |
| refetch_req | output | 1 | One-cycle request to fetch the entry again |
| refetch_idx | output | 4 | Index to fetch again |

## Verification
Lookups are driven with clean payloads of several kinds: all zeros, all ones, alternating bits and mixed patterns. These show that the stored parity agrees with what the check recomputes, whatever the density of set bits. Single flips are placed in the first and last payload bits, in odd bits and in each parity bit. They show that the two groups are kept apart and that the right flag reports each flip. Adjacent and same-group double flips separate what the interleaving catches from what it cannot catch. Back-to-back lookups, rereads after a fault, and a write colliding with a lookup of the same index pin down invalidation and the write-over-invalidate ordering.

// File: rtl/ilp_pkg.sv
package ilp_pkg;
    localparam int unsigned DEF_PAYLOAD_W = 71;
    localparam int unsigned DEF_ENTRIES   = 16;

    typedef enum logic [1:0] {
        LK_MISS  = 2'd0,
        LK_HIT   = 2'd1,
        LK_FAULT = 2'd2
    } lookup_e;
endpackage

// File: rtl/ilp_parity_gen.sv
module ilp_parity_gen #(
    parameter int unsigned WIDTH = 71
) (
    input  logic [WIDTH-1:0] data,
    output logic             par_even,
    output logic             par_odd
);
    logic [WIDTH-1:0] even_sel;
    logic [WIDTH-1:0] odd_sel;

    for (genvar i = 0; i < WIDTH; i++) begin : g_split
        if ((i % 2) == 0) begin : g_even
            assign even_sel[i] = data[i];
            assign odd_sel[i]  = 1'b0;
        end else begin : g_odd
            assign even_sel[i] = 1'b0;
            assign odd_sel[i]  = data[i];
        end
    end

    assign par_even = ^even_sel;
    assign par_odd  = ^odd_sel;
endmodule

// File: rtl/ilp_entry_store.sv
module ilp_entry_store #(
    parameter int unsigned ENTRIES = 16,
    parameter int unsigned CW      = 73,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [CW-1:0]    wr_word,
    input  logic             kill_en,
    input  logic [IDX_W-1:0] kill_idx,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [CW-1:0]    rd_word,
    output logic             rd_live
);
    logic [CW-1:0]      mem_d [ENTRIES];
    logic [CW-1:0]      mem_q [ENTRIES];
    logic [ENTRIES-1:0] live_d;
    logic [ENTRIES-1:0] live_q;

    always_comb begin
        live_d = live_q;
        for (int e = 0; e < ENTRIES; e++) begin
            mem_d[e] = mem_q[e];
        end
        // invalidation first, so a write to the same index wins
        if (kill_en) begin
            live_d[kill_idx] = 1'b0;
        end
        if (wr_en) begin
            mem_d[wr_idx]  = wr_word;
            live_d[wr_idx] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            live_q <= '0;
        end else begin
            live_q <= live_d;
        end
    end

    always_ff @(posedge clk) begin
        for (int e = 0; e < ENTRIES; e++) begin
            mem_q[e] <= mem_d[e];
        end
    end

    assign rd_word = mem_q[rd_idx];
    assign rd_live = live_q[rd_idx];
endmodule

// File: rtl/ilp_check.sv
module ilp_check #(
    parameter int unsigned WIDTH = 71,
    localparam int unsigned CW   = WIDTH + 2
) (
    input  logic             live,
    input  logic [CW-1:0]    word,
    output ilp_pkg::lookup_e status,
    output logic             err_even,
    output logic             err_odd
);
    import ilp_pkg::*;

    logic calc_even;
    logic calc_odd;

    ilp_parity_gen #(.WIDTH(WIDTH)) u_recalc (
        .data     (word[WIDTH-1:0]),
        .par_even (calc_even),
        .par_odd  (calc_odd)
    );

    always_comb begin
        err_even = 1'b0;
        err_odd  = 1'b0;
        status   = LK_MISS;
        if (live) begin
            err_even = calc_even ^ word[WIDTH];
            err_odd  = calc_odd ^ word[WIDTH+1];
            status   = (err_even || err_odd) ? LK_FAULT : LK_HIT;
        end
    end
endmodule

// File: rtl/ilp_entry_guard.sv
module ilp_entry_guard #(
    parameter int unsigned PAYLOAD_W = ilp_pkg::DEF_PAYLOAD_W,
    parameter int unsigned ENTRIES   = ilp_pkg::DEF_ENTRIES,
    localparam int unsigned IDX_W    = $clog2(ENTRIES),
    localparam int unsigned CW       = PAYLOAD_W + 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     wr_idx,
    input  logic [PAYLOAD_W-1:0] wr_payload,
    input  logic [CW-1:0]        wr_flip,
    input  logic                 rd_en,
    input  logic [IDX_W-1:0]     rd_idx,
    output logic                 rsp_valid,
    output logic                 rsp_hit,
    output logic [PAYLOAD_W-1:0] rsp_payload,
    output logic                 rsp_err_even,
    output logic                 rsp_err_odd,
    output logic                 refetch_req,
    output logic [IDX_W-1:0]     refetch_idx
);
    import ilp_pkg::*;

    typedef struct packed {
        logic                 valid;
        logic                 hit;
        logic [PAYLOAD_W-1:0] payload;
        logic                 err_even;
        logic                 err_odd;
        logic                 refetch;
        logic [IDX_W-1:0]     idx;
    } rsp_t;

    rsp_t rsp_d;
    rsp_t rsp_q;

    // write side: build the protected codeword
    logic          gen_even;
    logic          gen_odd;
    logic [CW-1:0] wr_word;

    ilp_parity_gen #(.WIDTH(PAYLOAD_W)) u_gen (
        .data     (wr_payload),
        .par_even (gen_even),
        .par_odd  (gen_odd)
    );

    assign wr_word = {gen_odd, gen_even, wr_payload} ^ wr_flip;

    // storage
    logic [CW-1:0] rd_word;
    logic          rd_live;
    logic          kill_en;

    ilp_entry_store #(.ENTRIES(ENTRIES), .CW(CW)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_word  (wr_word),
        .kill_en  (kill_en),
        .kill_idx (rd_idx),
        .rd_idx   (rd_idx),
        .rd_word  (rd_word),
        .rd_live  (rd_live)
    );

    // read side: recompute and compare
    lookup_e chk_status;
    logic    chk_even;
    logic    chk_odd;

    ilp_check #(.WIDTH(PAYLOAD_W)) u_check (
        .live     (rd_live),
        .word     (rd_word),
        .status   (chk_status),
        .err_even (chk_even),
        .err_odd  (chk_odd)
    );

    assign kill_en = rd_en && (chk_status == LK_FAULT);

    always_comb begin
        rsp_d = '0;
        if (rd_en) begin
            rsp_d.valid = 1'b1;
            rsp_d.idx   = rd_idx;
            unique case (chk_status)
                LK_HIT: begin
                    rsp_d.hit     = 1'b1;
                    rsp_d.payload = rd_word[PAYLOAD_W-1:0];
                end
                LK_FAULT: begin
                    rsp_d.err_even = chk_even;
                    rsp_d.err_odd  = chk_odd;
                    rsp_d.refetch  = 1'b1;
                end
                default: begin
                    rsp_d.hit = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid    = rsp_q.valid;
    assign rsp_hit      = rsp_q.hit;
    assign rsp_payload  = rsp_q.payload;
    assign rsp_err_even = rsp_q.err_even;
    assign rsp_err_odd  = rsp_q.err_odd;
    assign refetch_req  = rsp_q.refetch;
    assign refetch_idx  = rsp_q.idx;
endmodule

// File: rtl/ilp_entry_guard_sva.sv
module ilp_entry_guard_sva #(
    parameter int unsigned IDX_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [IDX_W-1:0] wr_idx,
    input logic             rd_en,
    input logic [IDX_W-1:0] rd_idx,
    input logic             rsp_valid,
    input logic             rsp_hit,
    input logic             rsp_err_even,
    input logic             rsp_err_odd,
    input logic             refetch_req,
    input logic [IDX_W-1:0] refetch_idx
);
    assert_resp_follows_lookup_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rsp_valid);

    assert_no_stray_resp_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rsp_valid);

    assert_refetch_on_miss_R5: assert property (@(posedge clk) disable iff (!rst_n)
        refetch_req |-> (rsp_valid && !rsp_hit && (rsp_err_even || rsp_err_odd)));

    assert_refetch_index_R5: assert property (@(posedge clk) disable iff (!rst_n)
        refetch_req |-> (refetch_idx == $past(rd_idx)));

    assert_hit_is_clean_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> (!rsp_err_even && !rsp_err_odd));

    assert_fault_invalidates_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (refetch_req && rd_en && (rd_idx == refetch_idx)
         && !($past(wr_en) && ($past(wr_idx) == refetch_idx)))
        |=> (rsp_valid && !rsp_hit && !refetch_req));
endmodule

bind ilp_entry_guard ilp_entry_guard_sva #(.IDX_W(IDX_W)) u_sva (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_idx       (wr_idx),
    .rd_en        (rd_en),
    .rd_idx       (rd_idx),
    .rsp_valid    (rsp_valid),
    .rsp_hit      (rsp_hit),
    .rsp_err_even (rsp_err_even),
    .rsp_err_odd  (rsp_err_odd),
    .refetch_req  (refetch_req),
    .refetch_idx  (refetch_idx)
);

// File: tb/ilp_entry_guard_test.sv
`timescale 1ns/1ps
module ilp_entry_guard_test;
    localparam int W  = 71;
    localparam int CW = 73;
    localparam int N  = 16;
    localparam int IW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [IW-1:0] wr_idx = '0;
    logic [W-1:0]  wr_payload = '0;
    logic [CW-1:0] wr_flip = '0;
    logic          rd_en = 1'b0;
    logic [IW-1:0] rd_idx = '0;
    logic          rsp_valid, rsp_hit, rsp_err_even, rsp_err_odd, refetch_req;
    logic [W-1:0]  rsp_payload;
    logic [IW-1:0] refetch_idx;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ilp_entry_guard uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_payload(wr_payload), .wr_flip(wr_flip), .rd_en(rd_en), .rd_idx(rd_idx),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_payload(rsp_payload),
        .rsp_err_even(rsp_err_even), .rsp_err_odd(rsp_err_odd),
        .refetch_req(refetch_req), .refetch_idx(refetch_idx)
    );

    typedef struct {
        bit           hit;
        logic [W-1:0] payload;
        bit           ee;
        bit           eo;
        bit           rf;
        int           idx;
        string        req;
    } exp_t;

    exp_t         sbq[$];
    logic [CW-1:0] m_word [N];
    bit            m_vld [N];

    function automatic logic [W-1:0] group_mask(bit odd);
        logic [W-1:0] m;
        for (int i = 0; i < W; i++) m[i] = ((i % 2) == 1) == odd;
        return m;
    endfunction

    function automatic logic [W-1:0] pat(int s);
        logic [W-1:0] p;
        for (int i = 0; i < W; i++) p[i] = (((i * s) + (s / 3)) % 5) < 2;
        return p;
    endfunction

    function automatic logic [CW-1:0] bitmask(int k);
        logic [CW-1:0] m;
        m = '0;
        m[k] = 1'b1;
        return m;
    endfunction

    function automatic exp_t predict(int ri);
        exp_t e;
        logic [CW-1:0] w;
        bit pe, po;
        w = m_word[ri];
        e.hit = 0; e.payload = '0; e.ee = 0; e.eo = 0; e.rf = 0; e.idx = ri; e.req = "";
        if (m_vld[ri]) begin
            pe = (^(w[W-1:0] & group_mask(1'b0))) ^ w[W];
            po = (^(w[W-1:0] & group_mask(1'b1))) ^ w[W+1];
            if (pe || po) begin
                e.ee = pe; e.eo = po; e.rf = 1;
            end else begin
                e.hit = 1; e.payload = w[W-1:0];
            end
        end
        return e;
    endfunction

    task automatic check(string req, string what, logic [W-1:0] act, logic [W-1:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    task automatic op(bit we, int wi, logic [W-1:0] wd, logic [CW-1:0] fl,
                      bit re, int ri, string req);
        exp_t e;
        @(negedge clk);
        wr_en = we; wr_idx = IW'(wi); wr_payload = wd; wr_flip = fl;
        rd_en = re; rd_idx = IW'(ri);
        if (re) begin
            e = predict(ri);
            e.req = req;
            sbq.push_back(e);
            if (e.rf) m_vld[ri] = 0;
        end
        if (we) begin
            m_word[wi] = {^(wd & group_mask(1'b1)), ^(wd & group_mask(1'b0)), wd} ^ fl;
            m_vld[wi] = 1;
        end
    endtask

    task automatic wr(int i, logic [W-1:0] d, logic [CW-1:0] fl);
        op(1, i, d, fl, 0, 0, "");
    endtask

    task automatic rd(int i, string req);
        op(0, 0, '0, '0, 1, i, req);
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) op(0, 0, '0, '0, 0, 0, "");
    endtask

    // monitor: pop one expectation per response
    always @(negedge clk) begin
        exp_t e;
        if (rst_n && !done) begin
            if (rsp_valid) begin
                if (sbq.size() == 0) begin
                    check("R3", "unexpected response", W'(1), W'(0));
                end else begin
                    e = sbq.pop_front();
                    check(e.req, "hit", W'(rsp_hit), W'(e.hit));
                    check(e.req, "payload", rsp_payload, e.payload);
                    check(e.req, "err_even", W'(rsp_err_even), W'(e.ee));
                    check(e.req, "err_odd", W'(rsp_err_odd), W'(e.eo));
                    check(e.req, "refetch_req", W'(refetch_req), W'(e.rf));
                    if (e.rf) check(e.req, "refetch_idx", W'(refetch_idx), W'(e.idx));
                end
            end else begin
                check("R5", "refetch without response", W'(refetch_req), W'(0));
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) begin m_word[i] = '0; m_vld[i] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "rsp_valid after reset", W'(rsp_valid), W'(0));
        check("R1", "refetch after reset", W'(refetch_req), W'(0));

        // R1 R9: every entry misses after reset
        for (int i = 0; i < N; i++) rd(i, "R1");

        // R2: clean patterns, back-to-back reads also cover R3
        wr(0, '0, '0);
        wr(1, '1, '0);
        wr(2, group_mask(1'b0), '0);
        wr(3, group_mask(1'b1), '0);
        wr(4, pat(7), '0);
        wr(5, pat(13), '0);
        for (int i = 0; i < 6; i++) rd(i, "R2");
        idle(1);
        rd(4, "R3");
        idle(2);
        rd(5, "R3");

        // R4: single flips in each group and each parity bit
        wr(6, pat(3), bitmask(0));
        wr(7, pat(5), bitmask(70));
        wr(8, pat(9), bitmask(1));
        wr(9, pat(11), bitmask(71));
        wr(10, pat(17), bitmask(72));
        wr(11, '1, bitmask(69));
        for (int i = 6; i < 12; i++) rd(i, "R4 R5");

        // R6: reads after fault miss without refetch
        rd(6, "R6");
        rd(9, "R6");
        rd(10, "R6");
        // rewrite restores the entry
        wr(6, pat(21), '0);
        rd(6, "R6");

        // R7: adjacent pairs
        wr(12, pat(23), bitmask(10) | bitmask(11));
        wr(13, '0, bitmask(70) | bitmask(69));
        rd(12, "R7");
        rd(13, "R7");

        // R8: two even bits go unseen
        wr(14, pat(29), bitmask(2) | bitmask(4));
        rd(14, "R8");
        rd(14, "R8");

        // R9: never-written entry
        rd(15, "R9");

        // R10: same-cycle write and read see old contents
        op(1, 1, pat(31), '0, 1, 1, "R10");
        rd(1, "R10");
        // faulty entry read while rewritten: refetch fires, write wins
        wr(2, pat(37), bitmask(5));
        op(1, 2, pat(41), '0, 1, 2, "R10");
        rd(2, "R10");
        // faulty entry read without rewrite next to a write elsewhere
        wr(3, pat(43), bitmask(8));
        op(1, 4, pat(47), '0, 1, 3, "R5");
        rd(3, "R6");
        rd(4, "R2");

        idle(4);
        check("R3", "responses outstanding", W'(sbq.size()), W'(0));
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule